// File: doc/BRIEF.md
# Dual-Endpoint Packet Buffer Controller

This block holds two small packet buffers, one for the control endpoint and one for the interrupt endpoint. It sits between a microcontroller and a USB serial interface engine. The engine drops received packets into a buffer and drains packets that are queued for transmission. The microcontroller claims one buffer at a time through a control/status register and moves bytes through a single data port.

A microcontroller access is a handshake. Software picks the buffer and the direction, raises the request bit, and moves bytes while the ready bit stays high. It then inverts the direction bit while the request is still held, which commits the transfer, and finally drops the request. A committed read frees the buffer for the next host packet. A committed write hands the packet and its length to the engine. Two status flags are sticky: one marks that a buffer holds a SETUP packet, the other marks that the host sent an empty packet.

Top module: `ep_pkt_fifo`

## Requirements
- R1: After reset both buffers are free and empty. The status register reads 0x00, no transmit packet is pending, and the transmit length and data outputs read 0.
- R2: An engine byte for a pipe is stored when that buffer is free, holds fewer than 8 bytes and is not held by the microcontroller. The byte flagged last turns the buffer into a received packet. Any other offered byte is refused: `eng_rx_nak` is high in the same cycle and the byte is dropped.
- R3: While the request bit is 1 and the pipe select equals a buffer's index, engine bytes for that buffer are refused and leave its contents unchanged.
- R4: The read handshake starts when the request bit rises with the direction bit (bit 1) at 0 on a received packet. Ready (status bit 6) is 1 while unread bytes remain. `mcu_dat_rdata` shows the next byte in arrival order, and each `mcu_dat_re` consumes one byte. Ready falls after the last byte. The read data output is 0 whenever read-ready is low.
- R5: With the request still 1, a control write that flips the direction from 0 to 1 commits the read and frees the buffer, so the engine can deposit a new packet.
- R6: The write handshake starts when the request bit rises with direction 1 on a free buffer. The buffer count restarts at zero and ready stays 1 while fewer than 8 bytes are written. Each `mcu_dat_we` stores one byte. Ready falls at 8 bytes.
- R7: With the request still 1, flipping the direction from 1 to 0 commits the write. `eng_tx_pend` bit n goes to 1, and `eng_tx_len` and `eng_tx_data` give the length and the bytes in written order, one per `eng_tx_pop`. `eng_tx_done` returns the buffer to free. A commit with no bytes gives a pending packet of length 0.
- R8: A control write with bit 2 set empties the buffer named by the select field of the same write, whatever the state of ready. Bit 2 always reads back 0.
- R9: The SETUP flag (status bit 5) of a buffer is set when a packet marked SETUP completes. It is cleared only by a control write with bit 5 at 0 that selects that buffer. Writing 1 keeps it.
- R10: An empty packet (`eng_rx_zero`) on a free, empty buffer sets its zero-length flag (status bit 7) and makes it a received packet of length 0. The flag clears on a data-port read strobe during a read request to that buffer, or on `eng_setup_tok`, which affects buffer 0 only.
- R11: Status layout: bit 0 request, bit 1 direction, bit 2 zero, bits 4:3 pipe select (00 buffer 0, 01 buffer 1), bit 5 SETUP flag, bit 6 ready, bit 7 zero-length flag. Both flags are those of the selected buffer.
- R12: Pipe select values 10 and 11 name no buffer. Ready stays 0, no buffer is held, and engine traffic to both buffers is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mcu_ctl_we | input | 1 | Control register write strobe |
| mcu_ctl_wdata | input | 8 | Control register write value |
| mcu_ctl_rdata | output | 8 | Control/status register read value |
| mcu_dat_we | input | 1 | Data port write strobe |
| mcu_dat_re | input | 1 | Data port read strobe |
| mcu_dat_wdata | input | DW | Data port write byte |
| mcu_dat_rdata | output | DW | Data port read byte |
| eng_rx_valid | input | 1 | Engine offers a receive byte or empty packet |
| eng_rx_pipe | input | PW | Target buffer of the receive offer |
| eng_rx_data | input | DW | Receive byte |
| eng_rx_last | input | 1 | Byte closes the packet |
| eng_rx_zero | input | 1 | Offer is an empty packet, no byte |
| eng_rx_setup | input | 1 | Packet is a SETUP command |
| eng_rx_nak | output | 1 | Offer refused this cycle |
| eng_setup_tok | input | 1 | Valid SETUP token seen on the control endpoint |
| eng_tx_pipe | input | PW | Buffer addressed on the transmit side |
| eng_tx_pop | input | 1 | Consume one transmit byte |
| eng_tx_done | input | 1 | Transmit packet finished, release buffer |
| eng_tx_pend | output | NBUF | Per-buffer transmit packet pending |
| eng_tx_len | output | CW | Length of the addressed pending packet |
| eng_tx_data | output | DW | Next byte of the addressed pending packet |

## Verification
The bench keeps a reference model of each buffer's contents, state and flags, and of the software handshake session. It compares the status register, both data outputs, the refusal signal and the transmit outputs against that model after every clock. If a buffer count, read pointer or state goes wrong, the ready bit or the next data byte disagrees in the very next cycle. If a handshake session decodes wrongly, the commit is missed, and this shows at once on `eng_tx_pend` or as a refusal of the next host packet. Flag faults show in bit 5 or bit 7 of the status register as soon as that buffer is selected.

// File: rtl/epf_pkg.sv
package epf_pkg;

  typedef enum logic [1:0] {
    BS_FREE   = 2'd0,
    BS_RXFULL = 2'd1,
    BS_TXPEND = 2'd2
  } bstate_e;

  localparam int CTL_REQ  = 0;
  localparam int CTL_DIR  = 1;
  localparam int CTL_CLR  = 2;
  localparam int CTL_SEL  = 3;
  localparam int CTL_KEEP = 5;
  localparam int CTL_RDY  = 6;
  localparam int CTL_ZLP  = 7;

endpackage

// File: rtl/epf_buf.sv
module epf_buf
  import epf_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic          commit_rd_i,
  input  logic          commit_wr_i,
  input  logic          tx_done_i,
  input  logic          tx_pop_i,
  input  logic          start_wr_i,
  input  logic          mcu_wr_i,
  input  logic [DW-1:0] mcu_wdata_i,
  input  logic          mcu_rd_i,
  input  logic          rd_any_i,
  input  logic          eng_wr_i,
  input  logic [DW-1:0] eng_wdata_i,
  input  logic          eng_last_i,
  input  logic          eng_zero_i,
  input  logic          eng_setup_i,
  input  logic          tok_i,
  input  logic          setup_clr_i,
  output bstate_e       st_o,
  output logic [CW-1:0] cnt_o,
  output logic [CW-1:0] ptr_o,
  output logic [DW-1:0] rdata_o,
  output logic          setup_o,
  output logic          zlp_o
);

  bstate_e       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] ptr_q, ptr_d;
  logic          su_q, su_d;
  logic          zl_q, zl_d;
  logic          eng_take;
  logic          mem_we;
  logic [DW-1:0] mem_wd;
  logic [DW-1:0] mem_q [DEPTH];

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    ptr_d    = ptr_q;
    mem_we   = 1'b0;
    mem_wd   = '0;
    eng_take = 1'b0;
    if (clr_i) begin
      st_d  = BS_FREE;
      cnt_d = '0;
      ptr_d = '0;
    end else if (commit_rd_i && st_q == BS_RXFULL) begin
      st_d  = BS_FREE;
      cnt_d = '0;
      ptr_d = '0;
    end else if (commit_wr_i && st_q == BS_FREE) begin
      st_d  = BS_TXPEND;
      ptr_d = '0;
    end else if (tx_done_i && st_q == BS_TXPEND) begin
      st_d  = BS_FREE;
      cnt_d = '0;
      ptr_d = '0;
    end else if (start_wr_i && st_q == BS_FREE) begin
      cnt_d = '0;
    end else if (mcu_wr_i) begin
      mem_we = 1'b1;
      mem_wd = mcu_wdata_i;
      cnt_d  = cnt_q + CW'(1);
    end else if (eng_wr_i) begin
      eng_take = 1'b1;
      if (!eng_zero_i) begin
        mem_we = 1'b1;
        mem_wd = eng_wdata_i;
        cnt_d  = cnt_q + CW'(1);
      end
      if (eng_zero_i || eng_last_i) begin
        st_d  = BS_RXFULL;
        ptr_d = '0;
      end
    end else if (mcu_rd_i || tx_pop_i) begin
      ptr_d = ptr_q + CW'(1);
    end
  end

  always_comb begin
    su_d = su_q;
    if (eng_take && (eng_zero_i || eng_last_i) && eng_setup_i) su_d = 1'b1;
    else if (setup_clr_i)                                       su_d = 1'b0;
    zl_d = zl_q;
    if (eng_take && eng_zero_i)  zl_d = 1'b1;
    else if (tok_i || rd_any_i)  zl_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= BS_FREE;
      cnt_q <= '0;
      ptr_q <= '0;
      su_q  <= 1'b0;
      zl_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      ptr_q <= ptr_d;
      su_q  <= su_d;
      zl_q  <= zl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem_q[cnt_q[AW-1:0]] <= mem_wd;
  end

  assign st_o    = st_q;
  assign cnt_o   = cnt_q;
  assign ptr_o   = ptr_q;
  assign rdata_o = mem_q[ptr_q[AW-1:0]];
  assign setup_o = su_q;
  assign zlp_o   = zl_q;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

  // R7
  txpend_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == BS_TXPEND) |-> $past(commit_wr_i));

  // R9
  setup_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(su_q) |-> $past(setup_clr_i));

  // R10
  zlp_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(zl_q) |-> $past(eng_wr_i && eng_zero_i));

endmodule

// File: rtl/epf_mcu_port.sv
module epf_mcu_port
  import epf_pkg::*;
#(
  parameter int NBUF  = 2,
  parameter int DEPTH = 8,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we_i,
  input  logic [7:0]    ctl_wdata_i,
  input  bstate_e       sel_st_i,
  input  logic [CW-1:0] sel_cnt_i,
  input  logic [CW-1:0] sel_ptr_i,
  output logic          req_o,
  output logic          dir_o,
  output logic [1:0]    sel_o,
  output logic          selv_o,
  output logic          wrm_o,
  output logic          done_o,
  output logic          ready_o,
  output logic [1:0]    new_sel_o,
  output logic          start_wr_o,
  output logic          commit_rd_o,
  output logic          commit_wr_o,
  output logic          clr_o,
  output logic          su_clr_o
);

  logic       req_q, req_d;
  logic       dir_q, dir_d;
  logic [1:0] sel_q, sel_d;
  logic       wrm_q, wrm_d;
  logic       done_q, done_d;
  logic [1:0] wsel;

  assign wsel = ctl_wdata_i[CTL_SEL +: 2];

  always_comb begin
    req_d       = req_q;
    dir_d       = dir_q;
    sel_d       = sel_q;
    wrm_d       = wrm_q;
    done_d      = done_q;
    start_wr_o  = 1'b0;
    commit_rd_o = 1'b0;
    commit_wr_o = 1'b0;
    clr_o       = 1'b0;
    su_clr_o    = 1'b0;
    if (ctl_we_i) begin
      req_d    = ctl_wdata_i[CTL_REQ];
      dir_d    = ctl_wdata_i[CTL_DIR];
      sel_d    = wsel;
      clr_o    = ctl_wdata_i[CTL_CLR];
      su_clr_o = !ctl_wdata_i[CTL_KEEP];
      if (!req_q && ctl_wdata_i[CTL_REQ]) begin
        wrm_d      = ctl_wdata_i[CTL_DIR];
        done_d     = 1'b0;
        start_wr_o = ctl_wdata_i[CTL_DIR];
      end else if (req_q && ctl_wdata_i[CTL_REQ] && !done_q &&
                   (ctl_wdata_i[CTL_DIR] != wrm_q) && (wsel == sel_q)) begin
        done_d      = 1'b1;
        commit_rd_o = !wrm_q;
        commit_wr_o = wrm_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      dir_q  <= 1'b0;
      sel_q  <= 2'b00;
      wrm_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      req_q  <= req_d;
      dir_q  <= dir_d;
      sel_q  <= sel_d;
      wrm_q  <= wrm_d;
      done_q <= done_d;
    end
  end

  assign selv_o    = (int'(sel_q) < NBUF);
  assign ready_o   = req_q && !done_q && selv_o &&
                     (wrm_q ? (sel_st_i == BS_FREE && sel_cnt_i < CW'(DEPTH))
                            : (sel_st_i == BS_RXFULL && sel_ptr_i < sel_cnt_i));
  assign req_o     = req_q;
  assign dir_o     = dir_q;
  assign sel_o     = sel_q;
  assign wrm_o     = wrm_q;
  assign done_o    = done_q;
  assign new_sel_o = wsel;

  // R4
  ready_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ready_o |-> req_q);

  // R12
  ready_needs_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_q[1] |-> !ready_o);

endmodule

// File: rtl/ep_pkt_fifo.sv
module ep_pkt_fifo
  import epf_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  parameter int NBUF  = 2,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int PW   = (NBUF > 1) ? $clog2(NBUF) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mcu_ctl_we,
  input  logic [7:0]      mcu_ctl_wdata,
  output logic [7:0]      mcu_ctl_rdata,
  input  logic            mcu_dat_we,
  input  logic            mcu_dat_re,
  input  logic [DW-1:0]   mcu_dat_wdata,
  output logic [DW-1:0]   mcu_dat_rdata,
  input  logic            eng_rx_valid,
  input  logic [PW-1:0]   eng_rx_pipe,
  input  logic [DW-1:0]   eng_rx_data,
  input  logic            eng_rx_last,
  input  logic            eng_rx_zero,
  input  logic            eng_rx_setup,
  output logic            eng_rx_nak,
  input  logic            eng_setup_tok,
  input  logic [PW-1:0]   eng_tx_pipe,
  input  logic            eng_tx_pop,
  input  logic            eng_tx_done,
  output logic [NBUF-1:0] eng_tx_pend,
  output logic [CW-1:0]   eng_tx_len,
  output logic [DW-1:0]   eng_tx_data
);

  bstate_e       st_a  [NBUF];
  logic [CW-1:0] cnt_a [NBUF];
  logic [CW-1:0] ptr_a [NBUF];
  logic [DW-1:0] rd_a  [NBUF];
  logic          su_a  [NBUF];
  logic          zl_a  [NBUF];
  logic [NBUF-1:0] held;

  bstate_e       sel_st;
  logic [CW-1:0] sel_cnt, sel_ptr;
  logic [DW-1:0] sel_rd;
  logic          sel_su, sel_zl;

  logic       req, dir, selv, wrm, done, ready;
  logic [1:0] sel, new_sel;
  logic       start_wr, commit_rd, commit_wr, clr, su_clr;

  logic          rx_acc, rx_held;
  bstate_e       rx_st;
  logic [CW-1:0] rx_cnt;
  bstate_e       tx_st;
  logic [CW-1:0] tx_cnt, tx_ptr;
  logic [DW-1:0] tx_rd;

  epf_mcu_port #(.NBUF(NBUF), .DEPTH(DEPTH)) u_mcu (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctl_we_i    (mcu_ctl_we),
    .ctl_wdata_i (mcu_ctl_wdata),
    .sel_st_i    (sel_st),
    .sel_cnt_i   (sel_cnt),
    .sel_ptr_i   (sel_ptr),
    .req_o       (req),
    .dir_o       (dir),
    .sel_o       (sel),
    .selv_o      (selv),
    .wrm_o       (wrm),
    .done_o      (done),
    .ready_o     (ready),
    .new_sel_o   (new_sel),
    .start_wr_o  (start_wr),
    .commit_rd_o (commit_rd),
    .commit_wr_o (commit_wr),
    .clr_o       (clr),
    .su_clr_o    (su_clr)
  );

  // Selection muxes for the software side, receive side and transmit side.
  always_comb begin
    sel_st  = BS_FREE;
    sel_cnt = '0;
    sel_ptr = '0;
    sel_rd  = '0;
    sel_su  = 1'b0;
    sel_zl  = 1'b0;
    rx_st   = BS_FREE;
    rx_cnt  = '0;
    rx_held = 1'b0;
    tx_st   = BS_FREE;
    tx_cnt  = '0;
    tx_ptr  = '0;
    tx_rd   = '0;
    for (int b = 0; b < NBUF; b++) begin
      if (sel == 2'(b)) begin
        sel_st  = st_a[b];
        sel_cnt = cnt_a[b];
        sel_ptr = ptr_a[b];
        sel_rd  = rd_a[b];
        sel_su  = su_a[b];
        sel_zl  = zl_a[b];
      end
      if (eng_rx_pipe == PW'(b)) begin
        rx_st   = st_a[b];
        rx_cnt  = cnt_a[b];
        rx_held = held[b];
      end
      if (eng_tx_pipe == PW'(b)) begin
        tx_st  = st_a[b];
        tx_cnt = cnt_a[b];
        tx_ptr = ptr_a[b];
        tx_rd  = rd_a[b];
      end
    end
  end

  assign rx_acc = eng_rx_valid && !rx_held && rx_st == BS_FREE &&
                  (eng_rx_zero ? (rx_cnt == '0) : (rx_cnt < CW'(DEPTH)));

  genvar gb;
  generate
    for (gb = 0; gb < NBUF; gb++) begin : g_buf
      logic hit_cur, hit_new, hit_rx, hit_tx;
      logic tx_avail;
      assign hit_cur   = (sel == 2'(gb));
      assign hit_new   = (new_sel == 2'(gb));
      assign hit_rx    = (eng_rx_pipe == PW'(gb));
      assign hit_tx    = (eng_tx_pipe == PW'(gb));
      assign held[gb]  = req && hit_cur;
      assign tx_avail  = (st_a[gb] == BS_TXPEND);
      assign eng_tx_pend[gb] = tx_avail;

      epf_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr && hit_new),
        .commit_rd_i (commit_rd && hit_cur),
        .commit_wr_i (commit_wr && hit_cur),
        .tx_done_i   (eng_tx_done && hit_tx && tx_avail),
        .tx_pop_i    (eng_tx_pop && hit_tx && tx_avail && (ptr_a[gb] < cnt_a[gb])),
        .start_wr_i  (start_wr && hit_new),
        .mcu_wr_i    (mcu_dat_we && ready && wrm && hit_cur),
        .mcu_wdata_i (mcu_dat_wdata),
        .mcu_rd_i    (mcu_dat_re && ready && !wrm && hit_cur),
        .rd_any_i    (mcu_dat_re && req && !wrm && !done && hit_cur),
        .eng_wr_i    (rx_acc && hit_rx),
        .eng_wdata_i (eng_rx_data),
        .eng_last_i  (eng_rx_last),
        .eng_zero_i  (eng_rx_zero),
        .eng_setup_i (eng_rx_setup),
        .tok_i       (eng_setup_tok && (gb == 0)),
        .setup_clr_i (su_clr && hit_new),
        .st_o        (st_a[gb]),
        .cnt_o       (cnt_a[gb]),
        .ptr_o       (ptr_a[gb]),
        .rdata_o     (rd_a[gb]),
        .setup_o     (su_a[gb]),
        .zlp_o       (zl_a[gb])
      );
    end
  endgenerate

  assign mcu_ctl_rdata = {sel_zl && selv, ready, sel_su && selv, sel, 1'b0, dir, req};
  assign mcu_dat_rdata = (ready && !wrm) ? sel_rd : '0;
  assign eng_rx_nak    = eng_rx_valid && !rx_acc;
  assign eng_tx_len    = (tx_st == BS_TXPEND) ? tx_cnt : '0;
  assign eng_tx_data   = (tx_st == BS_TXPEND && tx_ptr < tx_cnt) ? tx_rd : '0;

  // R3
  held_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_rx_valid && rx_held) |-> eng_rx_nak);

  // R7
  tx_len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_tx_len <= CW'(DEPTH));

endmodule

// File: tb/ep_pkt_fifo_tb.sv
module ep_pkt_fifo_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ctl_we;
  logic [7:0] ctl_wd;
  logic [7:0] ctl_rd;
  logic       dat_we, dat_re;
  logic [7:0] dat_wd, dat_rd;
  logic       rx_valid, rx_pipe, rx_last, rx_zero, rx_setup, rx_nak;
  logic [7:0] rx_data;
  logic       setup_tok;
  logic       tx_pipe, tx_pop, tx_done;
  logic [1:0] tx_pend;
  logic [3:0] tx_len;
  logic [7:0] tx_data;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  // reference model
  int       m_st [2];
  int       m_cnt[2];
  int       m_ptr[2];
  bit       m_su [2];
  bit       m_zl [2];
  bit [7:0] m_mem[2][8];
  bit       m_req, m_dir, m_sw, m_done;
  int       m_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  ep_pkt_fifo u_dut (
    .clk(clk), .rst_n(rst_n),
    .mcu_ctl_we(ctl_we), .mcu_ctl_wdata(ctl_wd), .mcu_ctl_rdata(ctl_rd),
    .mcu_dat_we(dat_we), .mcu_dat_re(dat_re), .mcu_dat_wdata(dat_wd), .mcu_dat_rdata(dat_rd),
    .eng_rx_valid(rx_valid), .eng_rx_pipe(rx_pipe), .eng_rx_data(rx_data),
    .eng_rx_last(rx_last), .eng_rx_zero(rx_zero), .eng_rx_setup(rx_setup), .eng_rx_nak(rx_nak),
    .eng_setup_tok(setup_tok),
    .eng_tx_pipe(tx_pipe), .eng_tx_pop(tx_pop), .eng_tx_done(tx_done),
    .eng_tx_pend(tx_pend), .eng_tx_len(tx_len), .eng_tx_data(tx_data)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit e_ready();
    if (!m_req || m_done || m_sel > 1) return 0;
    if (m_sw) return (m_st[m_sel] == 0 && m_cnt[m_sel] < 8);
    return (m_st[m_sel] == 1 && m_ptr[m_sel] < m_cnt[m_sel]);
  endfunction

  function automatic bit e_acc();
    int p = int'(rx_pipe);
    if (!rx_valid) return 0;
    if (m_req && m_sel == p) return 0;
    if (m_st[p] != 0) return 0;
    return rx_zero ? (m_cnt[p] == 0) : (m_cnt[p] < 8);
  endfunction

  task automatic compare_all();
    int s = m_sel;
    int p = int'(tx_pipe);
    bit r = e_ready();
    bit [7:0] ectl;
    ectl = {(s < 2) ? m_zl[s] : 1'b0, r, (s < 2) ? m_su[s] : 1'b0, 2'(s), 1'b0, m_dir, m_req};
    chk("R11 status", ctl_rd, ectl);
    chk("R4 read data", dat_rd, (r && !m_sw) ? m_mem[s][m_ptr[s]] : 0);
    chk("R2 refusal", rx_nak, rx_valid && !e_acc());
    chk("R7 pending", tx_pend, {m_st[1] == 2, m_st[0] == 2});
    chk("R7 length", tx_len, (m_st[p] == 2) ? m_cnt[p] : 0);
    chk("R7 data", tx_data, (m_st[p] == 2 && m_ptr[p] < m_cnt[p]) ? m_mem[p][m_ptr[p]] : 0);
  endtask

  task automatic model_step();
    bit r = e_ready();
    bit a = e_acc();
    int s = m_sel;
    int p = int'(rx_pipe);
    int t = int'(tx_pipe);
    if (ctl_we) begin
      int sn = int'(ctl_wd[4:3]);
      if (ctl_wd[2] && sn < 2) begin m_st[sn] = 0; m_cnt[sn] = 0; m_ptr[sn] = 0; end
      if (!m_req && ctl_wd[0]) begin
        m_sw = ctl_wd[1]; m_done = 0;
        if (ctl_wd[1] && sn < 2 && m_st[sn] == 0) m_cnt[sn] = 0;
      end else if (m_req && ctl_wd[0] && !m_done && ctl_wd[1] != m_sw && sn == m_sel) begin
        m_done = 1;
        if (sn < 2) begin
          if (!m_sw && m_st[sn] == 1) begin m_st[sn] = 0; m_cnt[sn] = 0; m_ptr[sn] = 0; end
          if (m_sw && m_st[sn] == 0) begin m_st[sn] = 2; m_ptr[sn] = 0; end
        end
      end
      if (!ctl_wd[5] && sn < 2) m_su[sn] = 0;
      m_req = ctl_wd[0]; m_dir = ctl_wd[1]; m_sel = sn;
    end
    if (dat_we && r && m_sw) begin m_mem[s][m_cnt[s]] = dat_wd; m_cnt[s]++; end
    if (dat_re && m_req && !m_sw && !m_done && s < 2) begin
      m_zl[s] = 0;
      if (r) m_ptr[s]++;
    end
    if (a) begin
      if (rx_zero) begin m_zl[p] = 1; m_st[p] = 1; m_ptr[p] = 0; end
      else begin
        m_mem[p][m_cnt[p]] = rx_data; m_cnt[p]++;
        if (rx_last) begin m_st[p] = 1; m_ptr[p] = 0; end
      end
      if ((rx_zero || rx_last) && rx_setup) m_su[p] = 1;
    end
    if (setup_tok) m_zl[0] = 0;
    if (tx_pop && m_st[t] == 2 && m_ptr[t] < m_cnt[t]) m_ptr[t]++;
    if (tx_done && m_st[t] == 2) begin m_st[t] = 0; m_cnt[t] = 0; m_ptr[t] = 0; end
  endtask

  task automatic idle_inputs();
    ctl_we = 0; ctl_wd = 0; dat_we = 0; dat_re = 0; dat_wd = 0;
    rx_valid = 0; rx_pipe = 0; rx_data = 0; rx_last = 0; rx_zero = 0; rx_setup = 0;
    setup_tok = 0; tx_pop = 0; tx_done = 0;
  endtask

  task automatic cyc();
    #1;
    compare_all();
    @(posedge clk);
    model_step();
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic ctl(input bit [7:0] w);
    ctl_we = 1; ctl_wd = w; cyc();
  endtask

  task automatic rxb(input bit p, input bit [7:0] d, input bit last, input bit su);
    rx_valid = 1; rx_pipe = p; rx_data = d; rx_last = last; rx_setup = su; cyc();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    tx_pipe = 0;
    rst_n = 0;
    for (int b = 0; b < 2; b++) begin
      m_st[b] = 0; m_cnt[b] = 0; m_ptr[b] = 0; m_su[b] = 0; m_zl[b] = 0;
    end
    m_req = 0; m_dir = 0; m_sw = 0; m_done = 0; m_sel = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    chk("R1 status", ctl_rd, 0);
    chk("R1 pending", tx_pend, 0);
    chk("R1 length", tx_len, 0);
    cyc();

    // R2: three-byte packet into buffer 1
    rxb(1, 8'hA1, 0, 0); rxb(1, 8'hA2, 0, 0); rxb(1, 8'hA3, 1, 0);
    // R4: read handshake on buffer 1
    ctl(8'h29);
    #1 chk("R4 ready up", ctl_rd[6], 1);
    for (int i = 0; i < 3; i++) begin
      #1 chk("R4 byte order", dat_rd, 8'hA1 + i);
      dat_re = 1; cyc();
    end
    #1 chk("R4 ready down", ctl_rd[6], 0);
    // R5: commit by flipping direction, then release
    ctl(8'h2B);
    ctl(8'h2A);
    rx_valid = 1; rx_pipe = 1; rx_data = 8'hB1;
    #1 chk("R5 freed accepts", rx_nak, 0);
    cyc();

    // R3: buffer 0 held by software refuses engine bytes
    ctl(8'h21);
    rx_valid = 1; rx_pipe = 0; rx_data = 8'hEE; rx_last = 1;
    #1 chk("R3 held refused", rx_nak, 1);
    cyc();
    ctl(8'h20);
    // R8: clear buffer 1 (partial packet) while not ready
    ctl(8'h2C);
    #1 chk("R8 clear reads zero", ctl_rd[2], 0);
    // R10: empty packet on now-empty buffer 1
    rx_valid = 1; rx_pipe = 1; rx_zero = 1;
    #1 chk("R8 empty after clear", rx_nak, 0);
    cyc();
    ctl(8'h29);
    #1 chk("R10 flag set", ctl_rd[7], 1);
    chk("R10 no ready", ctl_rd[6], 0);
    dat_re = 1; cyc();
    #1 chk("R10 cleared by read", ctl_rd[7], 0);
    ctl(8'h2B); ctl(8'h2A);

    // R9: SETUP packet of 8 bytes in buffer 0
    for (int i = 0; i < 8; i++) rxb(0, 8'h10 + i, i == 7, i == 7);
    rx_valid = 1; rx_pipe = 0; rx_data = 8'h99;
    #1 chk("R2 full refused", rx_nak, 1);
    cyc();
    ctl(8'h21);
    #1 chk("R9 setup set", ctl_rd[5], 1);
    for (int i = 0; i < 8; i++) begin
      #1 chk("R4 byte order", dat_rd, 8'h10 + i);
      dat_re = 1; cyc();
    end
    ctl(8'h23); ctl(8'h20);
    #1 chk("R9 setup kept", ctl_rd[5], 1);
    ctl(8'h00);
    #1 chk("R9 setup cleared", ctl_rd[5], 0);

    // R10: empty packet on buffer 0 cleared by SETUP token
    rx_valid = 1; rx_pipe = 0; rx_zero = 1; cyc();
    #1 chk("R10 flag buf0", ctl_rd[7], 1);
    setup_tok = 1; cyc();
    #1 chk("R10 token clears", ctl_rd[7], 0);
    ctl(8'h24);

    // R6: write 8 bytes into buffer 1
    ctl(8'h2B);
    #1 chk("R6 ready up", ctl_rd[6], 1);
    for (int i = 0; i < 8; i++) begin
      dat_we = 1; dat_wd = 8'hC0 + i; cyc();
    end
    #1 chk("R6 ready down at 8", ctl_rd[6], 0);
    // R7: commit write and drain on engine side
    ctl(8'h29);
    tx_pipe = 1;
    #1 chk("R7 pend", tx_pend, 2'b10);
    chk("R7 len", tx_len, 8);
    ctl(8'h28);
    for (int i = 0; i < 8; i++) begin
      #1 chk("R7 tx order", tx_data, 8'hC0 + i);
      tx_pop = 1; cyc();
    end
    tx_done = 1; cyc();
    #1 chk("R7 released", tx_pend, 0);

    // R12: select value 10 holds nothing
    ctl(8'h31);
    #1 chk("R12 no ready", ctl_rd[6], 0);
    rx_valid = 1; rx_pipe = 0; rx_data = 8'h55; rx_last = 1;
    #1 chk("R12 buf0 accepts", rx_nak, 0);
    cyc();
    rx_valid = 1; rx_pipe = 1; rx_data = 8'h66;
    #1 chk("R12 buf1 accepts", rx_nak, 0);
    cyc();
    ctl(8'h30);
    ctl(8'h24);

    // R7: empty write commit on buffer 0
    tx_pipe = 0;
    ctl(8'h23); ctl(8'h21);
    #1 chk("R7 empty pend", tx_pend[0], 1);
    chk("R7 empty len", tx_len, 0);
    ctl(8'h20);
    tx_done = 1; cyc();
    cyc();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule